// File: doc/BRIEF.md
# Synchronous Shift Port

This block is a clocked serial channel that exchanges 8-bit words with a peripheral, least significant bit first. Each transfer is full duplex. While the outgoing word is shifted out on `sdo`, an incoming word is shifted in from `sdi` on the same edges. The shift clock comes from one of two sources, chosen by `cfg_clk_out`. The port can generate the clock itself from a half-period divider and drive it on `sclk_out`. Otherwise it follows an external clock on `sclk_in`, and `cfg_fall_edge` selects whether the rising or the falling edge of that clock is active.

A transfer starts only when a word is accepted on the transmit stream. Words go into the port through a valid/ready pair. `tx_ready` is high only while the port is idle, and a source may hold `tx_valid` until it is accepted. If `tx_valid` is offered during a transfer, the word is not taken, and each such cycle is reported on `tx_busy_err`.

Received words go from the shift register into a second holding buffer. This buffer drives the receive stream: `rx_valid` stays high and `rx_data` stays stable until the consumer asserts `rx_ready`. The serial side cannot be held back. A word that completes while the buffer still holds unread data is therefore dropped and reported as an overrun. The end of each word is marked by a transmit interrupt pulse, and either a receive interrupt pulse or an overrun pulse. All of these pulses occur in the same cycle.

Top module: `sshift_port`

## Requirements
- R1: `tx_ready` is high while idle. A cycle with `tx_valid` and `tx_ready` both high accepts `tx_data`. `tx_ready` is low from the next cycle until the word has completed.
- R2: From the cycle after acceptance, `sdo` presents bit 0 of the accepted word. Each active shift edge advances `sdo` to the next higher bit. `sdo` is high whenever no transfer is active.
- R3: With `cfg_clk_out`=1, `sclk_oe` is high and `sclk_out` idles high. `sclk_out` falls in the cycle after acceptance. Each low and high phase lasts `div_half` system clocks, and `div_half` must be nonzero. Exactly 8 rising edges occur per word, and the rising edge is the active one.
- R4: With `cfg_clk_out`=0, `sclk_in` passes through a two-flop synchroniser and then an edge detector. `cfg_fall_edge`=0 makes the rising edge active, and `cfg_fall_edge`=1 makes the falling edge active. Edges that arrive while no transfer is active are ignored.
- R5: `sdi` is sampled at each active edge. The first bit sampled becomes bit 0 of the received word.
- R6: `tx_irq` is a one-cycle pulse. In clock-output mode it occurs in the cycle in which `sclk_out` returns high for the 8th time. In clock-input mode it occurs on the third system clock after the 8th active edge reaches `sclk_in`. It never occurs mid-word.
- R7: On completion, the word is moved into the receive buffer if the buffer is empty or is being read in that same cycle. `rx_valid` then goes high, and `rx_irq` pulses in the same cycle as `tx_irq`.
- R8: On completion with the buffer full and `rx_ready` low, `rx_overrun` pulses instead of `rx_irq`. `rx_data` keeps the unread word.
- R9: A `tx_valid` offered while `tx_ready` is low is not accepted. `tx_busy_err` pulses in the next cycle, and the running transfer continues unchanged.
- R10: The buffer empties in a cycle with `rx_valid` and `rx_ready` both high. While `rx_valid` is high and `rx_ready` is low, `rx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_out | input | 1 | 1: port generates the shift clock; 0: external clock |
| cfg_fall_edge | input | 1 | External mode: 0 rising, 1 falling edge active |
| div_half | input | DIV_W | Half-period of the generated clock in system clocks |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Port idle, word will be taken |
| tx_data | input | WORD_W | Word to send |
| tx_busy_err | output | 1 | Pulse: word offered during a transfer |
| rx_valid | output | 1 | Receive buffer holds a word |
| rx_ready | input | 1 | Consumer takes the buffered word |
| rx_data | output | WORD_W | Buffered received word |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Generated shift clock |
| sclk_oe | output | 1 | Drive enable for the shift clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| tx_irq | output | 1 | Pulse: word sent |
| rx_irq | output | 1 | Pulse: word placed in buffer |
| rx_overrun | output | 1 | Pulse: completed word dropped, buffer full |

## Verification
Some properties are checked on every cycle:
- the generated clock idles high between words and produces exactly eight rising edges per word;
- `sdo` idles high;
- an offer during a transfer raises the busy flag;
- a held receive word stays stable;
- every receive or overrun pulse coincides with a transmit pulse.

Other properties only the bench scenarios can show:
- the bit order and received values;
- the phase length set by `div_half`;
- the polarity chosen by `cfg_fall_edge`;
- the synchroniser latency;
- that an overrun keeps the old word;
- that a read in the completion cycle frees the slot for the new word.

// File: rtl/sshift_pkg.sv
package sshift_pkg;
  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_INT = 1'b1
  } clk_src_e;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/sshift_clkgen.sv
// Half-period divider producing the port-driven shift clock.
// Idles high; falls on start; 'rise' marks the cycle that sets it high.
module sshift_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output logic             rise
);
  logic [DIV_W-1:0] hcnt;
  logic [DIV_W-1:0] reload;

  assign reload = (half_div == '0) ? '0 : half_div - DIV_W'(1);
  assign rise   = run && !start && (hcnt == '0) && !sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk <= 1'b1;
      hcnt <= '0;
    end else if (start) begin
      sclk <= 1'b0;
      hcnt <= reload;
    end else if (run) begin
      if (hcnt == '0) begin
        sclk <= ~sclk;
        hcnt <= reload;
      end else begin
        hcnt <= hcnt - DIV_W'(1);
      end
    end else begin
      sclk <= 1'b1;
      hcnt <= '0;
    end
  end
endmodule

// File: rtl/sshift_insync.sv
// Synchroniser for the external clock and serial input, with edge detect.
// Data and clock share the same latency so a detected edge sees aligned data.
module sshift_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic sdi,
  output logic sdi_s,
  output logic ck_rise,
  output logic ck_fall
);
  logic [STAGES:0]   ck_p;
  logic [STAGES-1:0] d_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_p <= '1;
      d_p  <= '1;
    end else begin
      ck_p <= {ck_p[STAGES-1:0], sclk_in};
      d_p  <= {d_p[STAGES-2:0], sdi};
    end
  end

  assign sdi_s   = d_p[STAGES-1];
  assign ck_rise =  ck_p[STAGES-1] && !ck_p[STAGES];
  assign ck_fall = !ck_p[STAGES-1] &&  ck_p[STAGES];
endmodule

// File: rtl/sshift_core.sv
// Shared shift register: sends LSB first from bit 0, fills from the top.
module sshift_core #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_int,
  input  logic              edge_fall,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              clk_rise,
  input  logic              ext_rise,
  input  logic              ext_fall,
  input  logic              sdi_s,
  output logic              busy,
  output logic              accept,
  output logic              done,
  output logic              sdo,
  output logic [WORD_W-1:0] rx_word
);
  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;

  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              ext_step;
  logic              step;
  logic              last;

  assign accept   = tx_valid && !busy;
  assign ext_step = edge_fall ? ext_fall : ext_rise;
  assign step     = busy && (mode_int ? clk_rise : ext_step);
  assign last     = (cnt == CNT_W'(WORD_W - 1));
  assign done     = step && last;
  assign rx_word  = {sdi_s, sh[WORD_W-1:1]};
  assign sdo      = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      sh   <= tx_data;
      cnt  <= '0;
    end else if (step) begin
      sh  <= rx_word;
      cnt <= cnt + CNT_W'(1);
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/sshift_rxbuf.sv
// Second receive stage: holds one word for the consumer, never overwritten.
module sshift_rxbuf #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [WORD_W-1:0] word,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_irq,
  output logic              rx_overrun
);
  logic slot_free;

  assign slot_free = !rx_valid || rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_irq     <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      rx_irq     <= 1'b0;
      rx_overrun <= 1'b0;
      if (done && slot_free) begin
        rx_data  <= word;
        rx_valid <= 1'b1;
        rx_irq   <= 1'b1;
      end else if (done) begin
        rx_overrun <= 1'b1;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sshift_port.sv
module sshift_port
  import sshift_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_clk_out,
  input  logic              cfg_fall_edge,
  input  logic [DIV_W-1:0]  div_half,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_busy_err,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sdi,
  output logic              sdo,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              rx_overrun
);
  clk_src_e          src;
  edge_sel_e         esel;
  logic              mode_int;
  logic              busy;
  logic              accept;
  logic              done;
  logic              gen_rise;
  logic              ext_rise;
  logic              ext_fall;
  logic              sdi_s;
  logic [WORD_W-1:0] rx_word;

  assign src      = clk_src_e'(cfg_clk_out);
  assign esel     = edge_sel_e'(cfg_fall_edge);
  assign mode_int = (src == SRC_INT);
  assign sclk_oe  = mode_int;
  assign tx_ready = !busy;

  sshift_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_in (sclk_in),
    .sdi     (sdi),
    .sdi_s   (sdi_s),
    .ck_rise (ext_rise),
    .ck_fall (ext_fall)
  );

  sshift_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept && mode_int),
    .run      (busy && mode_int),
    .half_div (div_half),
    .sclk     (sclk_out),
    .rise     (gen_rise)
  );

  sshift_core #(.WORD_W(WORD_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_int  (mode_int),
    .edge_fall (esel == EDGE_FALL),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .clk_rise  (gen_rise),
    .ext_rise  (ext_rise),
    .ext_fall  (ext_fall),
    .sdi_s     (sdi_s),
    .busy      (busy),
    .accept    (accept),
    .done      (done),
    .sdo       (sdo),
    .rx_word   (rx_word)
  );

  sshift_rxbuf #(.WORD_W(WORD_W)) u_rxbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .word       (rx_word),
    .rx_ready   (rx_ready),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_irq     (rx_irq),
    .rx_overrun (rx_overrun)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_irq      <= 1'b0;
      tx_busy_err <= 1'b0;
    end else begin
      tx_irq      <= done;
      tx_busy_err <= tx_valid && busy;
    end
  end
endmodule

// File: rtl/sshift_port_chk.sv
module sshift_port_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_clk_out,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              tx_busy_err,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [WORD_W-1:0] rx_data,
  input logic              sclk_out,
  input logic              sdo,
  input logic              tx_irq,
  input logic              rx_irq,
  input logic              rx_overrun
);
  logic        sclk_d;
  int unsigned pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b1;
      pcnt   <= 0;
    end else begin
      sclk_d <= sclk_out;
      if (tx_valid && tx_ready) pcnt <= 0;
      else if (sclk_out && !sclk_d) pcnt <= pcnt + 1;
    end
  end

  p_ready_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);

  p_sdo_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> sdo);

  p_clk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk_out && tx_ready |-> sclk_out);

  p_eight_pulses_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq && cfg_clk_out |-> (pcnt + ((sclk_out && !sclk_d) ? 1 : 0)) == WORD_W);

  p_done_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq || rx_overrun |-> tx_irq);

  p_irq_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_valid);

  p_irq_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_irq && rx_overrun));

  p_busy_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_busy_err);

  p_hold_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));
endmodule

bind sshift_port sshift_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_clk_out (cfg_clk_out),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_busy_err (tx_busy_err),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .rx_data     (rx_data),
  .sclk_out    (sclk_out),
  .sdo         (sdo),
  .tx_irq      (tx_irq),
  .rx_irq      (rx_irq),
  .rx_overrun  (rx_overrun)
);

// File: tb/sim_sshift_port.sv
module sim_sshift_port;
  localparam int W  = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cfg_clk_out, cfg_fall_edge;
  logic [DW-1:0] div_half;
  logic          tx_valid, tx_ready, tx_busy_err;
  logic [W-1:0]  tx_data, rx_data;
  logic          rx_valid, rx_ready;
  logic          sclk_in, sclk_out, sclk_oe, sdi, sdo;
  logic          tx_irq, rx_irq, rx_overrun;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit mdl_full = 1'b0;
  logic [W-1:0] mdl_data = '0;

  sshift_port #(.WORD_W(W), .DIV_W(DW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_clk_out(cfg_clk_out), .cfg_fall_edge(cfg_fall_edge),
    .div_half(div_half), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_busy_err(tx_busy_err), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .rx_overrun(rx_overrun)
  );

  always @(posedge clk) cyc++;

  // Completion stores the word when the buffer is empty or being read (R7).
  function automatic bit stores(bit full, bit rdy);
    return !full || rdy;
  endfunction

  // Bit k of a word as sent or received, LSB first (R2, R5).
  function automatic logic bit_at(logic [W-1:0] w, int k);
    return w[k];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    wait (cyc >= 150000);
    n_chk++;
    n_err++;
    $display("FAIL R1 watchdog: act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic check_done(logic [W-1:0] rw, bit rdy);
    bit st;
    st = stores(mdl_full, rdy);
    chk("R7 rx_irq at completion", 32'(rx_irq), 32'(st));
    chk("R8 rx_overrun at completion", 32'(rx_overrun), 32'(!st));
    if (st) mdl_data = rw;
    mdl_full = 1'b1;
    chk("R7 rx_valid after completion", 32'(rx_valid), 1);
    chk(st ? "R5 received word" : "R8 buffer not overwritten", 32'(rx_data), 32'(mdl_data));
  endtask

  task automatic set_mode(bit intm, bit fall);
    cfg_clk_out   = intm;
    cfg_fall_edge = fall;
    if (!intm) sclk_in = fall;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_rx();
    chk("R10 rx_valid before read", 32'(rx_valid), 32'(mdl_full));
    if (mdl_full) begin
      chk("R10 rx_data before read", 32'(rx_data), 32'(mdl_data));
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
      mdl_full = 1'b0;
      chk("R10 buffer empties on read", 32'(rx_valid), 0);
    end
  endtask

  task automatic xfer_out(logic [W-1:0] tw, logic [W-1:0] rw, int dv, bit poke);
    int rises, low, g, pk;
    bit prev, stray;
    rises = 0; low = 1; g = 0; pk = 0; stray = 1'b0;
    div_half = DW'(dv);
    chk("R1 ready while idle", 32'(tx_ready), 1);
    tx_valid = 1'b1;
    tx_data  = tw;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R1 ready drops after accept", 32'(tx_ready), 0);
    chk("R3 clock falls after accept", 32'(sclk_out), 0);
    chk("R3 oe in output mode", 32'(sclk_oe), 1);
    chk("R2 first bit", 32'(sdo), 32'(bit_at(tw, 0)));
    sdi  = bit_at(rw, 0);
    prev = 1'b0;
    while (rises < W && g < 5000) begin
      if (poke && rises == 3 && pk == 0) begin
        tx_valid = 1'b1;
        tx_data  = ~tw;
        pk = 1;
      end
      @(negedge clk);
      g++;
      if (pk == 1) begin
        tx_valid = 1'b0;
        pk = 2;
        chk("R9 busy flag", 32'(tx_busy_err), 1);
        chk("R9 offer not taken", 32'(tx_ready), 0);
      end
      if (!prev && sclk_out) begin
        rises++;
        if (rises == 1) chk("R3 low phase length", 32'(low), 32'(dv));
        if (rises < W) begin
          if (tx_irq) stray = 1'b1;
        end else begin
          chk("R6 tx_irq with final rise", 32'(tx_irq), 1);
          check_done(rw, 1'b0);
        end
      end else if (prev && !sclk_out) begin
        chk("R2 sdo bit", 32'(sdo), 32'(bit_at(tw, rises)));
        sdi = bit_at(rw, rises);
        low = 1;
      end else if (!sclk_out) begin
        low++;
      end
      prev = sclk_out;
    end
    chk("R3 eight clock pulses", 32'(rises), W);
    chk("R6 no mid-word tx_irq", 32'(stray), 0);
    @(negedge clk);
    chk("R3 clock idles high", 32'(sclk_out), 1);
    chk("R6 tx_irq one cycle", 32'(tx_irq), 0);
    chk("R1 ready after word", 32'(tx_ready), 1);
    chk("R2 sdo idles high", 32'(sdo), 1);
  endtask

  task automatic xfer_in(logic [W-1:0] tw, logic [W-1:0] rw, bit fall, bit early);
    bit idle, stray, rd_now;
    idle = fall; stray = 1'b0;
    chk("R1 ready while idle", 32'(tx_ready), 1);
    tx_valid = 1'b1;
    tx_data  = tw;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R3 oe off in input mode", 32'(sclk_oe), 0);
    for (int k = 0; k < W; k++) begin
      sdi = bit_at(rw, k);
      repeat (4) begin @(negedge clk); if (tx_irq) stray = 1'b1; end
      chk("R2 sdo bit", 32'(sdo), 32'(bit_at(tw, k)));
      sclk_in = ~idle;
      if (k < W - 1) begin
        repeat (6) begin @(negedge clk); if (tx_irq) stray = 1'b1; end
        sclk_in = idle;
      end else begin
        rd_now = early && mdl_full;
        @(negedge clk);
        chk("R4 sync latency stage 1", 32'(tx_irq), 0);
        @(negedge clk);
        chk("R4 sync latency stage 2", 32'(tx_irq), 0);
        if (rd_now) rx_ready = 1'b1;
        @(negedge clk);
        chk("R6 tx_irq after last active edge", 32'(tx_irq), 1);
        check_done(rw, rd_now);
        rx_ready = 1'b0;
        @(negedge clk);
        chk("R6 tx_irq one cycle", 32'(tx_irq), 0);
        sclk_in = idle;
        repeat (5) @(negedge clk);
      end
    end
    chk("R6 no mid-word tx_irq", 32'(stray), 0);
  endtask

  initial begin
    int seed_dummy;
    bit stray;
    bit m, f;
    logic [W-1:0] a, b;
    seed_dummy = int'($urandom(32'd20240611));
    cfg_clk_out = 1'b1; cfg_fall_edge = 1'b0; div_half = DW'(3);
    tx_valid = 1'b0; tx_data = '0; rx_ready = 1'b0; sclk_in = 1'b1; sdi = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(tx_ready), 1);
    chk("R3 clock high after reset", 32'(sclk_out), 1);
    chk("R2 sdo high after reset", 32'(sdo), 1);
    chk("R7 buffer empty after reset", 32'(rx_valid), 0);
    chk("R6 no tx_irq after reset", 32'(tx_irq), 0);

    // Generated clock, basic word, then hold and read.
    set_mode(1'b1, 1'b0);
    xfer_out(8'hA5, 8'h3C, 3, 1'b0);
    repeat (5) @(negedge clk);
    chk("R10 word held while not read", 32'(rx_data), 32'(mdl_data));
    read_rx();
    // Busy offer in mid-word.
    xfer_out(8'h81, 8'hFE, 5, 1'b1);
    read_rx();

    // External clock, idle edges ignored.
    set_mode(1'b0, 1'b0);
    stray = 1'b0;
    for (int t = 0; t < 6; t++) begin
      sclk_in = ~sclk_in;
      repeat (3) begin @(negedge clk); if (tx_irq || rx_irq || rx_overrun) stray = 1'b1; end
    end
    repeat (4) @(negedge clk);
    chk("R4 idle edges raise nothing", 32'(stray), 0);
    chk("R4 idle edges leave port ready", 32'(tx_ready), 1);
    xfer_in(8'h5A, 8'hC3, 1'b0, 1'b0);
    read_rx();

    // Falling edge: fill, overrun, read in the completion cycle.
    set_mode(1'b0, 1'b1);
    xfer_in(8'h0F, 8'h96, 1'b1, 1'b0);
    xfer_in(8'hF0, 8'h11, 1'b1, 1'b0);
    xfer_in(8'h22, 8'h77, 1'b1, 1'b1);
    read_rx();

    for (int i = 0; i < 24; i++) begin
      m = 1'($urandom);
      f = 1'($urandom);
      a = W'($urandom);
      b = W'($urandom);
      if (m != cfg_clk_out || f != cfg_fall_edge) set_mode(m, f);
      if (1'($urandom)) read_rx();
      if (m) xfer_out(a, b, 3 + int'($urandom % 4), ($urandom % 4) == 0);
      else   xfer_in(a, b, f, 1'($urandom));
    end
    read_rx();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule